// File: doc/BRIEF.md
# Clock-Generator Configuration I2C Slave

This block is the host-facing control port of a programmable clock generator. It listens on an I2C bus (SCL input, open-drain SDA), answers at one of two 7-bit addresses picked by a strap pin, and keeps a small bank of configuration and status registers. A transfer names a register pointer and then writes or reads one or more bytes. Reads use a repeated START.

The loop-control, feedback-divider and phase-resolution registers are double-buffered. Host writes land in a programmed copy. The copy that drives the clock generator changes only when the host writes a commit code to a write-only register. That write also emits a one-cycle reset strobe to the loop or to the phase-adjust circuit. Each nibble of the commit code is decoded on its own.

The block also selects what appears on the lock/reference status pin. The choices are constant low, the phase-adjust lock flag, the loop lock flag, or a reference signal. SCL and SDA are resynchronised and glitch-filtered inside the block before any edge is seen.

Top module: `clkcfg_i2c_bank`

## Requirements
- R1: The slave answers only to 7-bit address {6'b010011, addrSel}, which is byte 4Ch/4Dh when addrSel is 0 and 4Eh/4Fh when it is 1. It acknowledges by pulling SDA low in the ninth clock. For any other address it never drives SDA.
- R2: After reset the outputs read as follows: cfgCtl=01h, cfgLoop=00h, cfgFbDiv=FFFh, cfgPhaseOfs=00h, cfgPhaseRes=3, cfgOutEn=00h, cfgOsc=80h. SDA is released and both strobes are low.
- R3: In a write, bytes go MSB first. The first byte after the address is the register pointer, and every later byte is written at the pointer. The pointer then steps by one. Every byte is acknowledged.
- R4: A read after a repeated START returns the register at the pointer, MSB first, and steps the pointer after each byte. It continues while the host acknowledges and ends on a host NACK.
- R5: A write to register 08h with upper nibble 5h gives one cycle of pllResetStb. It also copies registers 01h–03h into cfgLoop and cfgFbDiv ({reg03h[3:0], reg02h}). Writes to 01h–03h alone do not change those outputs.
- R6: A write to register 08h with lower nibble Ah gives one cycle of dpaResetStb and copies register 05h bits 1:0 into cfgPhaseRes. The value 5Ah fires both commits. A value matching neither nibble fires none.
- R7: Register 10h reads 17h and register 11h reads 01h. Register 12h reads pllLock in bit 1 and dpaLock in bit 0, with zeros above.
- R8: Register 05h bits 7:2 read 0 until a write to 05h carries all ones in those bits. From then on they read the revision code REV_CODE.
- R9: Reads of write-only or unused addresses (08h, 09h, …) return 00h. Writes to the read-only registers 10h–12h are acknowledged and change nothing.
- R10: Reserved bits read 0: register 01h bits 3, 6 and 7, register 03h bits 7:4, and register 04h bit 6.
- R11: lockRefOut follows {reg00h[6], reg00h[7]}. 00 gives 0, 01 gives dpaLock, and 10 gives pllLock. With 11 it gives oscDivIn when reg07h[7]=1, and otherwise syncIn XOR reg00h[2].
- R12: An SCL or SDA pulse shorter than FILT_LEN system clocks has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | I2C clock line |
| sdaIn | input | 1 | I2C data line as seen on the bus |
| addrSel | input | 1 | Strap choosing the address LSB |
| dpaLock | input | 1 | Phase-adjust lock flag |
| pllLock | input | 1 | Loop lock flag |
| syncIn | input | 1 | Conditioned horizontal sync |
| oscDivIn | input | 1 | Divided oscillator reference |
| sdaOe | output | 1 | Pulls SDA low when 1 |
| cfgCtl | output | 8 | Input-control register |
| cfgLoop | output | 8 | Committed loop-control value |
| cfgFbDiv | output | 12 | Committed feedback divider |
| cfgPhaseOfs | output | 8 | Phase offset and filter select |
| cfgPhaseRes | output | 2 | Committed phase resolution |
| cfgOutEn | output | 8 | Output enables and clock scaler |
| cfgOsc | output | 8 | Oscillator divider and input select |
| pllResetStb | output | 1 | One-cycle loop reset/commit strobe |
| dpaResetStb | output | 1 | One-cycle phase-adjust reset/commit strobe |
| lockRefOut | output | 1 | Lock/reference status pin |

## Verification
The bench uses FILT_LEN=3 and a non-zero REV_CODE of 2Dh. With these values the revision bits of register 05h read differently before and after the unlock write. With an SCL quarter-phase of 8 clocks, a one-clock SCL spike falls inside the filter window while every real bus phase lasts longer than the sync-plus-filter delay. Both strap settings are driven, so the address match is tested with the pin low and with it high.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RDATA_ACK
  } busStateT;

  typedef struct packed {
    logic       wrEn;
    logic [7:0] addr;
    logic [7:0] data;
  } regWrT;

  localparam logic [7:0] A_CTL    = 8'h00;
  localparam logic [7:0] A_LOOP   = 8'h01;
  localparam logic [7:0] A_FBLO   = 8'h02;
  localparam logic [7:0] A_FBHI   = 8'h03;
  localparam logic [7:0] A_PHASE  = 8'h04;
  localparam logic [7:0] A_RES    = 8'h05;
  localparam logic [7:0] A_OUT    = 8'h06;
  localparam logic [7:0] A_OSC    = 8'h07;
  localparam logic [7:0] A_COMMIT = 8'h08;
  localparam logic [7:0] A_ID     = 8'h10;
  localparam logic [7:0] A_REV    = 8'h11;
  localparam logic [7:0] A_STAT   = 8'h12;

  localparam logic [7:0] M_LOOP  = 8'h37;
  localparam logic [7:0] M_FBHI  = 8'h0F;
  localparam logic [7:0] M_PHASE = 8'hBF;

endpackage

// File: rtl/clkcfg_i2c_ctrl.sv
module clkcfg_i2c_ctrl
  import clkcfg_pkg::*;
#(
  parameter int          FILT_LEN  = 3,
  parameter logic [5:0]  BASE_ADDR = 6'b010011
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        addrSel,
  input  logic [7:0]  rdData,
  output logic [7:0]  rdAddr,
  output regWrT       wrStb,
  output logic        sdaOe
);

  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0] rawIn;
  logic [1:0] lineF;
  logic [1:0] lineQ;
  assign rawIn = {sclIn, sdaIn};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_line
      logic [1:0]    syncR;
      logic [CW-1:0] cnt;
      logic          filtR;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncR <= 2'b11;
          cnt   <= '0;
          filtR <= 1'b1;
        end else begin
          syncR <= {syncR[0], rawIn[i]};
          if (syncR[1] != filtR) begin
            if (cnt == CW'(FILT_LEN - 1)) begin
              filtR <= syncR[1];
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            cnt <= '0;
          end
        end
      end
      assign lineF[i] = filtR;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineQ <= 2'b11;
    else       lineQ <= lineF;
  end

  logic sclF, sdaF, sclQ, sdaQ;
  assign sclF = lineF[1];
  assign sdaF = lineF[0];
  assign sclQ = lineQ[1];
  assign sdaQ = lineQ[0];

  logic startEv, stopEv, sclRise, sclFall;
  assign startEv = sclF && sclQ && sdaQ && !sdaF;
  assign stopEv  = sclF && sclQ && !sdaQ && sdaF;
  assign sclRise = sclF && !sclQ;
  assign sclFall = !sclF && sclQ;

  busStateT   state;
  logic [2:0] bitCnt;
  logic [7:0] shiftR;
  logic [7:0] txR;
  logic       byteFull;
  logic       rwBit;
  logic       nackR;
  logic [7:0] ptr;

  assign rdAddr = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      shiftR   <= '0;
      txR      <= '0;
      byteFull <= 1'b0;
      rwBit    <= 1'b0;
      nackR    <= 1'b0;
      ptr      <= '0;
      sdaOe    <= 1'b0;
      wrStb    <= '0;
    end else begin
      wrStb.wrEn <= 1'b0;
      if (startEv) begin
        state    <= S_ADDR;
        bitCnt   <= '0;
        byteFull <= 1'b0;
        sdaOe    <= 1'b0;
      end else if (stopEv) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else if (sclRise) begin
        case (state)
          S_ADDR, S_PTR, S_WDATA: begin
            shiftR <= {shiftR[6:0], sdaF};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) byteFull <= 1'b1;
          end
          S_RDATA: begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) byteFull <= 1'b1;
          end
          S_RDATA_ACK: nackR <= sdaF;
          default: ;
        endcase
      end else if (sclFall) begin
        case (state)
          S_ADDR: if (byteFull) begin
            byteFull <= 1'b0;
            if (shiftR[7:1] == {BASE_ADDR, addrSel}) begin
              rwBit <= shiftR[0];
              sdaOe <= 1'b1;
              state <= S_ADDR_ACK;
            end else begin
              state <= S_IDLE;
            end
          end
          S_ADDR_ACK: begin
            bitCnt <= '0;
            if (rwBit) begin
              txR   <= rdData;
              sdaOe <= ~rdData[7];
              state <= S_RDATA;
            end else begin
              sdaOe <= 1'b0;
              state <= S_PTR;
            end
          end
          S_PTR: if (byteFull) begin
            byteFull <= 1'b0;
            ptr      <= shiftR;
            sdaOe    <= 1'b1;
            state    <= S_PTR_ACK;
          end
          S_PTR_ACK, S_WDATA_ACK: begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            state  <= S_WDATA;
          end
          S_WDATA: if (byteFull) begin
            byteFull <= 1'b0;
            wrStb    <= '{wrEn: 1'b1, addr: ptr, data: shiftR};
            ptr      <= ptr + 8'd1;
            sdaOe    <= 1'b1;
            state    <= S_WDATA_ACK;
          end
          S_RDATA: begin
            if (byteFull) begin
              byteFull <= 1'b0;
              sdaOe    <= 1'b0;
              ptr      <= ptr + 8'd1;
              state    <= S_RDATA_ACK;
            end else begin
              txR   <= {txR[6:0], 1'b0};
              sdaOe <= ~txR[6];
            end
          end
          S_RDATA_ACK: begin
            if (nackR) begin
              state <= S_IDLE;
            end else begin
              txR    <= rdData;
              sdaOe  <= ~rdData[7];
              bitCnt <= '0;
              state  <= S_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: SDA is never pulled while no transfer is addressed to this slave
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaOe);

  // R4: SDA is driven only in acknowledge or read-data phases
  a_r4_drive_phases: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (state inside {S_ADDR_ACK, S_PTR_ACK, S_WDATA_ACK, S_RDATA}));

  // R3: the pointer has stepped past the byte just written
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.wrEn |-> (wrStb.addr + 8'd1 == ptr));

  // R3: one write strobe per received data byte
  a_r3_write_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.wrEn |=> !wrStb.wrEn);

endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
#(
  parameter logic [5:0] REV_CODE  = 6'h2D,
  parameter logic [7:0] ID_VALUE  = 8'h17,
  parameter logic [7:0] REV_VALUE = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  regWrT       wrStb,
  input  logic [7:0]  rdAddr,
  input  logic        dpaLock,
  input  logic        pllLock,
  input  logic        syncIn,
  input  logic        oscDivIn,
  output logic [7:0]  rdData,
  output logic [7:0]  cfgCtl,
  output logic [7:0]  cfgLoop,
  output logic [11:0] cfgFbDiv,
  output logic [7:0]  cfgPhaseOfs,
  output logic [1:0]  cfgPhaseRes,
  output logic [7:0]  cfgOutEn,
  output logic [7:0]  cfgOsc,
  output logic        pllResetStb,
  output logic        dpaResetStb,
  output logic        lockRefOut
);

  logic [7:0] loopR, fbLoR, fbHiR;
  logic [1:0] resR;
  logic       revOpen;

  logic pllHit, dpaHit;
  assign pllHit = wrStb.wrEn && (wrStb.addr == A_COMMIT) && (wrStb.data[7:4] == 4'h5);
  assign dpaHit = wrStb.wrEn && (wrStb.addr == A_COMMIT) && (wrStb.data[3:0] == 4'hA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgCtl      <= 8'h01;
      loopR       <= 8'h00;
      fbLoR       <= 8'hFF;
      fbHiR       <= 8'h0F;
      cfgPhaseOfs <= 8'h00;
      resR        <= 2'd3;
      revOpen     <= 1'b0;
      cfgOutEn    <= 8'h00;
      cfgOsc      <= 8'h80;
    end else if (wrStb.wrEn) begin
      case (wrStb.addr)
        A_CTL:   cfgCtl      <= wrStb.data;
        A_LOOP:  loopR       <= wrStb.data & M_LOOP;
        A_FBLO:  fbLoR       <= wrStb.data;
        A_FBHI:  fbHiR       <= wrStb.data & M_FBHI;
        A_PHASE: cfgPhaseOfs <= wrStb.data & M_PHASE;
        A_RES: begin
          resR <= wrStb.data[1:0];
          if (&wrStb.data[7:2]) revOpen <= 1'b1;
        end
        A_OUT:   cfgOutEn    <= wrStb.data;
        A_OSC:   cfgOsc      <= wrStb.data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLoop     <= 8'h00;
      cfgFbDiv    <= 12'hFFF;
      cfgPhaseRes <= 2'd3;
      pllResetStb <= 1'b0;
      dpaResetStb <= 1'b0;
    end else begin
      pllResetStb <= pllHit;
      dpaResetStb <= dpaHit;
      if (pllHit) begin
        cfgLoop  <= loopR;
        cfgFbDiv <= {fbHiR[3:0], fbLoR};
      end
      if (dpaHit) cfgPhaseRes <= resR;
    end
  end

  always_comb begin
    case (rdAddr)
      A_CTL:   rdData = cfgCtl;
      A_LOOP:  rdData = loopR;
      A_FBLO:  rdData = fbLoR;
      A_FBHI:  rdData = fbHiR;
      A_PHASE: rdData = cfgPhaseOfs;
      A_RES:   rdData = {revOpen ? REV_CODE : 6'd0, resR};
      A_OUT:   rdData = cfgOutEn;
      A_OSC:   rdData = cfgOsc;
      A_ID:    rdData = ID_VALUE;
      A_REV:   rdData = REV_VALUE;
      A_STAT:  rdData = {6'd0, pllLock, dpaLock};
      default: rdData = 8'h00;
    endcase
  end

  always_comb begin
    case ({cfgCtl[6], cfgCtl[7]})
      2'b00:   lockRefOut = 1'b0;
      2'b01:   lockRefOut = dpaLock;
      2'b10:   lockRefOut = pllLock;
      default: lockRefOut = cfgOsc[7] ? oscDivIn : (syncIn ^ cfgCtl[2]);
    endcase
  end

  // R5: the working loop settings equal the programmed copy when the strobe fires
  a_r5_commit_loads: assert property (@(posedge clk) disable iff (!rstN)
    pllResetStb |-> (cfgLoop == loopR && cfgFbDiv == {fbHiR[3:0], fbLoR}));

  // R5: working loop settings hold between commits
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !pllResetStb |-> ($stable(cfgLoop) && $stable(cfgFbDiv)));

  // R5: single-cycle loop strobe
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pllResetStb |=> !pllResetStb);

  // R6: working resolution equals the programmed copy on its strobe
  a_r6_commit_loads: assert property (@(posedge clk) disable iff (!rstN)
    dpaResetStb |-> (cfgPhaseRes == resR));

  // R6: resolution holds between commits
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dpaResetStb |-> $stable(cfgPhaseRes));

  // R8: once opened, the revision field stays visible
  a_r8_stays_open: assert property (@(posedge clk) disable iff (!rstN)
    $past(revOpen) |-> revOpen);

endmodule

// File: rtl/clkcfg_i2c_bank.sv
module clkcfg_i2c_bank
  import clkcfg_pkg::*;
#(
  parameter int         FILT_LEN  = 3,
  parameter logic [5:0] BASE_ADDR = 6'b010011,
  parameter logic [5:0] REV_CODE  = 6'h2D,
  parameter logic [7:0] ID_VALUE  = 8'h17,
  parameter logic [7:0] REV_VALUE = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        addrSel,
  input  logic        dpaLock,
  input  logic        pllLock,
  input  logic        syncIn,
  input  logic        oscDivIn,
  output logic        sdaOe,
  output logic [7:0]  cfgCtl,
  output logic [7:0]  cfgLoop,
  output logic [11:0] cfgFbDiv,
  output logic [7:0]  cfgPhaseOfs,
  output logic [1:0]  cfgPhaseRes,
  output logic [7:0]  cfgOutEn,
  output logic [7:0]  cfgOsc,
  output logic        pllResetStb,
  output logic        dpaResetStb,
  output logic        lockRefOut
);

  regWrT      wrStb;
  logic [7:0] rdAddr;
  logic [7:0] rdData;

  clkcfg_i2c_ctrl #(.FILT_LEN(FILT_LEN), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rdData(rdData), .rdAddr(rdAddr), .wrStb(wrStb), .sdaOe(sdaOe)
  );

  clkcfg_regs #(.REV_CODE(REV_CODE), .ID_VALUE(ID_VALUE), .REV_VALUE(REV_VALUE)) u_regs (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdAddr(rdAddr),
    .dpaLock(dpaLock), .pllLock(pllLock), .syncIn(syncIn), .oscDivIn(oscDivIn),
    .rdData(rdData), .cfgCtl(cfgCtl), .cfgLoop(cfgLoop), .cfgFbDiv(cfgFbDiv),
    .cfgPhaseOfs(cfgPhaseOfs), .cfgPhaseRes(cfgPhaseRes), .cfgOutEn(cfgOutEn),
    .cfgOsc(cfgOsc), .pllResetStb(pllResetStb), .dpaResetStb(dpaResetStb),
    .lockRefOut(lockRefOut)
  );

endmodule

// File: tb/clkcfg_i2c_bank_bench.sv
module clkcfg_i2c_bank_bench;

  localparam int         FILT = 3;
  localparam logic [5:0] REV  = 6'h2D;
  localparam int         Q    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic addrSel = 1'b0, dpaLock = 1'b1, pllLock = 1'b0, syncIn = 1'b0, oscDivIn = 1'b0;
  logic sdaOe, pllResetStb, dpaResetStb, lockRefOut;
  logic [7:0] cfgCtl, cfgLoop, cfgPhaseOfs, cfgOutEn, cfgOsc;
  logic [11:0] cfgFbDiv;
  logic [1:0] cfgPhaseRes;
  logic sdaLine;

  assign sdaLine = sdaDrv & ~sdaOe;

  always #10 clk = ~clk;

  clkcfg_i2c_bank #(.FILT_LEN(FILT), .REV_CODE(REV)) u_clkcfg_i2c_bank (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .addrSel(addrSel),
    .dpaLock(dpaLock), .pllLock(pllLock), .syncIn(syncIn), .oscDivIn(oscDivIn),
    .sdaOe(sdaOe), .cfgCtl(cfgCtl), .cfgLoop(cfgLoop), .cfgFbDiv(cfgFbDiv),
    .cfgPhaseOfs(cfgPhaseOfs), .cfgPhaseRes(cfgPhaseRes), .cfgOutEn(cfgOutEn),
    .cfgOsc(cfgOsc), .pllResetStb(pllResetStb), .dpaResetStb(dpaResetStb),
    .lockRefOut(lockRefOut)
  );

  int checks = 0;
  int errors = 0;
  int pllCnt = 0;
  int dpaCnt = 0;
  bit doneFlag = 1'b0;

  always @(posedge clk) begin
    if (pllResetStb) pllCnt <= pllCnt + 1;
    if (dpaResetStb) dpaCnt <= dpaCnt + 1;
  end

  typedef struct { logic [7:0] val; string tag; } expT;
  expT expQ[$];
  logic [7:0] rxVal;
  event rxEv;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectRd(input logic [7:0] v, input string tag);
    expT e;
    e.val = v;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // scoreboard monitor: compares each byte the host reads against the queue
  initial begin
    forever begin
      @(rxEv);
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: unexpected read byte %h expected none", rxVal);
      end else begin
        expT e;
        e = expQ.pop_front();
        chk(e.tag, {8'h0, rxVal}, {8'h0, e.val});
      end
    end
  end

  task automatic waitQ(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop;
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic busBit(input logic b, input bit glitch, output logic smp);
    sdaDrv = b;
    if (glitch) begin
      waitQ(3);
      sclDrv = 1'b1; waitQ(1);
      sclDrv = 1'b0; waitQ(Q - 4);
    end else begin
      waitQ();
    end
    sclDrv = 1'b1; waitQ();
    smp = sdaLine; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) busBit(b[i], glitch && (i == 4), s);
    busBit(1'b1, 1'b0, ack);
  endtask

  task automatic readByte(input bit hostAck);
    logic [7:0] v;
    logic s;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, 1'b0, s);
      v[i] = s;
    end
    busBit(~hostAck, 1'b0, s);
    rxVal = v;
    -> rxEv;
  endtask

  function automatic logic [7:0] devAddr(input logic rd);
    return {6'b010011, addrSel, rd};
  endfunction

  task automatic wr1(input logic [7:0] ptr, input logic [7:0] v, input bit glitch = 1'b0);
    logic a;
    busStart();
    sendByte(devAddr(1'b0), 1'b0, a); chk("R1 addr ack", {15'h0, a}, 16'h0);
    sendByte(ptr, 1'b0, a);           chk("R3 ptr ack", {15'h0, a}, 16'h0);
    sendByte(v, glitch, a);           chk("R3 data ack", {15'h0, a}, 16'h0);
    busStop();
  endtask

  task automatic wr2(input logic [7:0] ptr, input logic [7:0] v0, input logic [7:0] v1);
    logic a;
    busStart();
    sendByte(devAddr(1'b0), 1'b0, a); chk("R1 addr ack", {15'h0, a}, 16'h0);
    sendByte(ptr, 1'b0, a);           chk("R3 ptr ack", {15'h0, a}, 16'h0);
    sendByte(v0, 1'b0, a);            chk("R3 data0 ack", {15'h0, a}, 16'h0);
    sendByte(v1, 1'b0, a);            chk("R3 data1 ack", {15'h0, a}, 16'h0);
    busStop();
  endtask

  task automatic rdN(input logic [7:0] ptr, input int n);
    logic a;
    busStart();
    sendByte(devAddr(1'b0), 1'b0, a); chk("R1 addr ack", {15'h0, a}, 16'h0);
    sendByte(ptr, 1'b0, a);           chk("R3 ptr ack", {15'h0, a}, 16'h0);
    busStart();
    sendByte(devAddr(1'b1), 1'b0, a); chk("R4 read addr ack", {15'h0, a}, 16'h0);
    for (int i = 0; i < n; i++) readByte(i < n - 1);
    busStop();
  endtask

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2 reset state
    chk("R2 cfgCtl", {8'h0, cfgCtl}, 16'h01);
    chk("R2 cfgLoop", {8'h0, cfgLoop}, 16'h00);
    chk("R2 cfgFbDiv", {4'h0, cfgFbDiv}, 16'hFFF);
    chk("R2 cfgPhaseOfs", {8'h0, cfgPhaseOfs}, 16'h00);
    chk("R2 cfgPhaseRes", {14'h0, cfgPhaseRes}, 16'h3);
    chk("R2 cfgOutEn", {8'h0, cfgOutEn}, 16'h00);
    chk("R2 cfgOsc", {8'h0, cfgOsc}, 16'h80);
    chk("R2 sdaOe", {15'h0, sdaOe}, 16'h0);
    chk("R2 strobes", {14'h0, pllResetStb, dpaResetStb}, 16'h0);
    chk("R11 both enables off", {15'h0, lockRefOut}, 16'h0);

    // R7 / R4 sequential read of identity and status
    expectRd(8'h17, "R7 id");
    expectRd(8'h01, "R7 rev");
    expectRd(8'h01, "R7 status dpa");
    rdN(8'h10, 3);

    // R1 wrong address with strap low
    busStart();
    sendByte(8'h4E, 1'b0, a);
    chk("R1 foreign address nack", {15'h0, a}, 16'h1);
    busStop();

    // R1 strap high moves the address
    addrSel = 1'b1;
    busStart();
    sendByte(8'h4C, 1'b0, a);
    chk("R1 old address nack", {15'h0, a}, 16'h1);
    busStop();

    // R3 / R10 / R5 programmed copy versus working copy
    wr1(8'h01, 8'hFD);
    chk("R5 loop not yet committed", {8'h0, cfgLoop}, 16'h00);
    expectRd(8'h35, "R10 loop reserved bits");
    rdN(8'h01, 1);
    wr2(8'h02, 8'hFE, 8'hFA);
    expectRd(8'hFE, "R3 fb low");
    expectRd(8'h0A, "R10 fb high nibble");
    rdN(8'h02, 2);
    chk("R5 fbdiv not yet committed", {4'h0, cfgFbDiv}, 16'hFFF);
    wr1(8'h08, 8'h50);
    chk("R5 pll strobe count", pllCnt[15:0], 16'd1);
    chk("R6 no dpa strobe on 50h", dpaCnt[15:0], 16'd0);
    chk("R5 loop committed", {8'h0, cfgLoop}, 16'h35);
    chk("R5 fbdiv committed", {4'h0, cfgFbDiv}, 16'hAFE);

    // R8 revision unlock
    expectRd(8'h03, "R8 locked revision");
    rdN(8'h05, 1);
    wr1(8'h05, 8'h7E);
    expectRd(8'h02, "R8 partial ones");
    rdN(8'h05, 1);
    wr1(8'h05, 8'hFD);
    expectRd({REV, 2'b01}, "R8 unlocked revision");
    rdN(8'h05, 1);
    chk("R6 res not yet committed", {14'h0, cfgPhaseRes}, 16'h3);
    wr1(8'h08, 8'h3A);
    chk("R6 dpa strobe count", dpaCnt[15:0], 16'd1);
    chk("R5 no pll strobe on 3Ah", pllCnt[15:0], 16'd1);
    chk("R6 res committed", {14'h0, cfgPhaseRes}, 16'h1);

    // R6 combined and neutral codes
    wr1(8'h05, 8'hFE);
    wr1(8'h08, 8'h5A);
    chk("R6 5Ah pll", pllCnt[15:0], 16'd2);
    chk("R6 5Ah dpa", dpaCnt[15:0], 16'd2);
    chk("R6 5Ah res", {14'h0, cfgPhaseRes}, 16'h2);
    wr1(8'h08, 8'h33);
    chk("R6 neutral code pll", pllCnt[15:0], 16'd2);
    chk("R6 neutral code dpa", dpaCnt[15:0], 16'd2);

    // R9 read-only and unused addresses
    wr1(8'h10, 8'h55);
    expectRd(8'h17, "R9 id unchanged");
    rdN(8'h10, 1);
    expectRd(8'h00, "R9 commit reg reads zero");
    expectRd(8'h00, "R9 unused reads zero");
    rdN(8'h08, 2);

    // R12 glitch on SCL inside a data byte, R10 phase reserved bit
    wr1(8'h04, 8'h6A, 1'b1);
    chk("R12 glitch filtered", {8'h0, cfgPhaseOfs}, 16'h2A);
    expectRd(8'h2A, "R12 readback");
    rdN(8'h04, 1);

    // R11 lock/reference selection
    wr1(8'h00, 8'h81);
    waitQ(2); chk("R11 dpa lock high", {15'h0, lockRefOut}, 16'h1);
    dpaLock = 1'b0; waitQ(2); chk("R11 dpa lock low", {15'h0, lockRefOut}, 16'h0);
    wr1(8'h00, 8'h41);
    pllLock = 1'b1; waitQ(2); chk("R11 pll lock high", {15'h0, lockRefOut}, 16'h1);
    expectRd(8'h02, "R7 status pll");
    rdN(8'h12, 1);
    pllLock = 1'b0; waitQ(2); chk("R11 pll lock low", {15'h0, lockRefOut}, 16'h0);
    wr1(8'h07, 8'h00);
    wr1(8'h00, 8'hC1);
    syncIn = 1'b1; waitQ(2); chk("R11 sync pass", {15'h0, lockRefOut}, 16'h1);
    wr1(8'h00, 8'hC5);
    waitQ(2); chk("R11 sync inverted", {15'h0, lockRefOut}, 16'h0);
    wr1(8'h07, 8'h80);
    oscDivIn = 1'b1; waitQ(2); chk("R11 osc high", {15'h0, lockRefOut}, 16'h1);
    oscDivIn = 1'b0; waitQ(2); chk("R11 osc low", {15'h0, lockRefOut}, 16'h0);
    chk("R2 cfgOsc written", {8'h0, cfgOsc}, 16'h80);

    waitQ(4);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R4: %0d expected reads left, expected 0", expQ.size());
    end
    doneFlag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule